// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial bus (I2C) that gives a bus master byte-wide access to a register space of up to 256 locations. The bus lines are sampled with a fast system clock. Each line passes through a synchroniser and a short majority-free run-length filter before SCL edges and START/STOP conditions are detected. The slave pulls SDA low through a single open-drain enable output and never drives it high.

A transfer opens with an address byte made of a fixed four-bit identifier, three strap bits and a direction bit. A write carries a pointer byte and then data bytes. Each data byte is strobed onto the register port and the pointer then advances. A read is a pointer write, then a repeated START with the direction bit set, then bytes returned from successive locations until the master declines one. Every STOP is reported as a one-cycle pulse, so the register space can start a deferred commit.

Top module: `i2c_reg_slave`

## Requirements
- R1: The address byte is received MSB first as `1010`, then the three strap bits, then the direction bit (1 = read). The slave acknowledges it by holding SDA low for the ninth clock only when all seven upper bits match.
- R2: After an address byte that does not match, the slave gives no acknowledge, and it neither strobes the register port nor drives SDA until the next START.
- R3: In a write, the first byte after the address loads the pointer. Each later byte gives a one-cycle `reg_wr` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. Every received byte is acknowledged.
- R4: In a read, the byte at the pointer is sent MSB first. `reg_rd` pulses for one cycle, and `reg_rdata` is taken on the following cycle. SDA changes only while SCL is low, except when a START or STOP releases it.
- R5: The pointer advances by one after each data byte in both directions and wraps from FFh to 00h.
- R6: When the master NACKs a read byte, the slave releases SDA and stays off the line until the next START.
- R7: Every STOP produces exactly one single-cycle `stop_pulse` and returns the slave to idle.
- R8: A START or STOP in the middle of a byte discards the partial byte, which produces no register strobe, and restarts the receive logic.
- R9: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored.
- R10: During reset, `sda_oe`, `reg_wr`, `reg_rd` and `stop_pulse` are 0 and `reg_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_addr | input | 3 | Strap bits compared with address bits 3..1 |
| reg_addr | output | 8 | Register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |
| stop_pulse | output | 1 | One-cycle pulse on each STOP |

## Verification
Two things happen in the same system cycle in this block: loading the fetched read byte and advancing the pointer. When a read fetch completes at location FFh, that advance is also the wrap to 00h. The bench starts a two-byte read at FFh after writing FFh and 00h with a write that itself crosses the wrap. It judges the result by whether the second byte returned equals the value written to 00h, and not a stale or out-of-range location. Aborted bytes, glitches and NACK release are judged from the write-strobe count, the STOP count and the SDA line.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  localparam int          ID_W   = 4;
  localparam logic [3:0]  DEV_ID = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_TACK
  } slv_state_e;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        dout <= 1'b1;
      else if (~|hist_q)
        dout <= 1'b0;
    end
  end

  // R9: the filtered level only moves after a full run of equal samples
  a_r9_glitch_reject: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (($past(hist_q) == '0) || ($past(hist_q) == '1)));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise   = scl_f & ~scl_q;
    scl_fall   = ~scl_f & scl_q;
    cond_start = scl_f & scl_q & sda_q & ~sda_f;
    cond_stop  = scl_f & scl_q & ~sda_q & sda_f;
  end

endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 8,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               cond_start,
  input  logic               cond_stop,
  output logic               sda_oe,
  output logic [PTR_W-1:0]   reg_addr,
  output logic               reg_wr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_rdata,
  output logic               stop_pulse
);

  localparam int                CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DATA_W);

  slv_state_e          state_q;
  logic [CNT_W-1:0]    bcnt_q;
  logic [DATA_W-1:0]   rx_q;
  logic [DATA_W-1:0]   tx_q;
  logic [PTR_W-1:0]    ptr_q;
  logic                rw_q;
  logic                ack_q;
  logic                fetch_q;
  logic                addr_hit;

  assign reg_addr = ptr_q;
  assign addr_hit = (rx_q[DATA_W-1 -: ID_W] == DEV_ID) && (rx_q[STRAP_W:1] == strap);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bcnt_q     <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      ack_q      <= 1'b0;
      fetch_q    <= 1'b0;
      sda_oe     <= 1'b0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      reg_wdata  <= '0;
      stop_pulse <= 1'b0;
    end else begin
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      stop_pulse <= 1'b0;
      fetch_q    <= reg_rd;
      if (fetch_q) begin
        tx_q  <= reg_rdata;
        ptr_q <= ptr_q + 1'b1;
      end
      if (reg_wr)
        ptr_q <= ptr_q + 1'b1;

      if (cond_stop) begin
        state_q    <= ST_IDLE;
        sda_oe     <= 1'b0;
        bcnt_q     <= '0;
        stop_pulse <= 1'b1;
      end else if (cond_start) begin
        state_q <= ST_ADDR;
        sda_oe  <= 1'b0;
        bcnt_q  <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise && bcnt_q != FULL) begin
              rx_q   <= {rx_q[DATA_W-2:0], sda_f};
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall && bcnt_q == FULL) begin
              bcnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  rw_q    <= rx_q[0];
                  reg_rd  <= rx_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_PTR) begin
                ptr_q   <= PTR_W'(rx_q);
                sda_oe  <= 1'b1;
                state_q <= ST_PTR_ACK;
              end else begin
                reg_wr    <= 1'b1;
                reg_wdata <= rx_q;
                sda_oe    <= 1'b1;
                state_q   <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_PTR_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bcnt_q <= '0;
              if (state_q == ST_ADDR_ACK && rw_q) begin
                sda_oe  <= ~tx_q[DATA_W-1];
                tx_q    <= tx_q << 1;
                bcnt_q  <= CNT_W'(1);
                state_q <= ST_TX;
              end else if (state_q == ST_ADDR_ACK) begin
                state_q <= ST_PTR;
              end else begin
                state_q <= ST_WDAT;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt_q == FULL) begin
                sda_oe  <= 1'b0;
                ack_q   <= 1'b0;
                bcnt_q  <= '0;
                state_q <= ST_TACK;
              end else begin
                sda_oe <= ~tx_q[DATA_W-1];
                tx_q   <= tx_q << 1;
                bcnt_q <= bcnt_q + 1'b1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              ack_q  <= ~sda_f;
              reg_rd <= ~sda_f;
            end else if (scl_fall) begin
              if (ack_q) begin
                sda_oe  <= ~tx_q[DATA_W-1];
                tx_q    <= tx_q << 1;
                bcnt_q  <= CNT_W'(1);
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: begin
            bcnt_q <= '0;
          end
        endcase
      end
    end
  end

  // R4: SDA drive changes only while SCL is low, unless a condition releases it
  a_r4_sda_edge_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_f) || $past(cond_start) || $past(cond_stop)));

  // R3: the register port never writes and reads in one cycle
  a_r3_wr_rd_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  // R7: STOP indication lasts a single cycle
  a_r7_stop_single: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  // R5: pointer advances (with wrap) right after a write strobe
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

  // R6: when idle (after NACK, mismatch or STOP) the line is never pulled
  a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int DATA_W      = 8,
  parameter int PTR_W       = 8,
  parameter int STRAP_W     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_addr,
  output logic [PTR_W-1:0]   reg_addr,
  output logic               reg_wr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_rdata,
  output logic               stop_pulse
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_w;
  logic [N_LINES-1:0] filt_w;
  logic scl_rise, scl_fall, cond_start, cond_stop;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_flt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_w[g]),
      .dout (filt_w[g])
    );
  end

  i2c_bus_events u_evt (
    .clk        (clk),
    .rst        (rst),
    .scl_f      (filt_w[0]),
    .sda_f      (filt_w[1]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .cond_start (cond_start),
    .cond_stop  (cond_stop)
  );

  i2c_slave_core #(
    .DATA_W  (DATA_W),
    .PTR_W   (PTR_W),
    .STRAP_W (STRAP_W)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .strap      (strap_addr),
    .scl_f      (filt_w[0]),
    .sda_f      (filt_w[1]),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .cond_start (cond_start),
    .cond_stop  (cond_stop),
    .sda_oe     (sda_oe),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .stop_pulse (stop_pulse)
  );

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};
  localparam int NV = 7;
  // {expect_ack, dev7, ptr, data}
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 7'h55, 8'h10, 8'hA5},
    {1'b1, 7'h55, 8'h11, 8'h5A},
    {1'b0, 7'h54, 8'h12, 8'h77},
    {1'b0, 7'h25, 8'h13, 8'h66},
    {1'b1, 7'h55, 8'h80, 8'h00},
    {1'b1, 7'h55, 8'hF0, 8'hFF},
    {1'b0, 7'h51, 8'h10, 8'h11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, reg_wr, reg_rd, stop_pulse;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int wr_cnt, stop_cnt;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .strap_addr (STRAP),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .stop_pulse (stop_pulse)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      wr_cnt    <= 0;
      stop_cnt  <= 0;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) reg_rdata <= mem[reg_addr];
      if (stop_pulse) stop_cnt <= stop_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q(); q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i];
      if (glitch && i == 3) begin
        @(negedge clk); scl_m = 1'b1;
        @(negedge clk); scl_m = 1'b0;
      end
      q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, input bit glitch = 1'b0);
    send_bits(b, 8, glitch);
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    ack = ~sda_line;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    logic first;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q();
      first = sda_line;
      b[i] = first;
      q();
      chk("R4 sda stable while scl high", sda_line, first);
      scl_m = 1'b0;
    end
    q(); sda_m = nack; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic rd_seq(input logic [7:0] p, input int n, output logic [7:0] r0, output logic [7:0] r1);
    logic a;
    bus_start();
    send_byte(DEVW, a);
    send_byte(p, a);
    bus_rstart();
    send_byte(DEVR, a);
    chk("R1 read address ack", a, 1'b1);
    recv_byte(r0, n == 1);
    r1 = 8'h00;
    if (n == 2) recv_byte(r1, 1'b1);
    bus_stop();
  endtask

  initial begin
    logic a, a2, a3;
    logic [7:0] r0, r1;
    logic [23:0] e;
    int w0, s0;
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);

    repeat (5) @(negedge clk);
    chk("R10 sda_oe in reset", sda_oe, 1'b0);
    chk("R10 reg_wr in reset", reg_wr, 1'b0);
    chk("R10 reg_rd in reset", reg_rd, 1'b0);
    chk("R10 stop_pulse in reset", stop_pulse, 1'b0);
    chk("R10 reg_addr in reset", reg_addr, 8'h00);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // table walk: one-byte write with given address, then readback
    for (int v = 0; v < NV; v++) begin
      e  = VEC[v];
      w0 = wr_cnt;
      bus_start();
      send_byte({e[22:16], 1'b0}, a);
      chk("R1 R2 address ack matches identifier and strap", a, e[23]);
      send_byte(e[15:8], a2);
      send_byte(e[7:0], a3);
      chk("R2 R3 pointer byte ack", a2, e[23]);
      chk("R2 R3 data byte ack", a3, e[23]);
      bus_stop();
      chk("R2 R3 write strobe count", wr_cnt - w0, e[23] ? 1 : 0);
      if (e[23]) exp_mem[e[15:8]] = e[7:0];
      rd_seq(e[15:8], 1, r0, r1);
      chk("R3 R4 readback", r0, exp_mem[e[15:8]]);
    end

    // R5 wrap in write and read
    bus_start();
    send_byte(DEVW, a);
    send_byte(8'hFF, a);
    send_byte(8'h3C, a);
    send_byte(8'hC3, a);
    chk("R3 second data byte ack", a, 1'b1);
    bus_stop();
    exp_mem[8'hFF] = 8'h3C; exp_mem[8'h00] = 8'hC3;
    chk("R5 written at FFh", mem[8'hFF], 8'h3C);
    chk("R5 wrap write at 00h", mem[8'h00], 8'hC3);
    rd_seq(8'hFF, 2, r0, r1);
    chk("R5 read FFh", r0, 8'h3C);
    chk("R5 read wraps to 00h", r1, 8'hC3);

    // R5 multi-byte read in the middle of the map
    rd_seq(8'h10, 2, r0, r1);
    chk("R5 read 10h", r0, exp_mem[8'h10]);
    chk("R5 read 11h", r1, exp_mem[8'h11]);

    // R6 release after NACK, R7 single stop pulse
    bus_start();
    send_byte(DEVR, a);
    recv_byte(r0, 1'b1);
    chk("R6 read after stale pointer", r0, exp_mem[8'h12]);
    chk("R6 sda released after nack", sda_oe, 1'b0);
    scl_m = 1'b1; q(); q();
    chk("R6 no drive on extra clock", sda_line, 1'b1);
    scl_m = 1'b0; q();
    s0 = stop_cnt;
    bus_stop();
    chk("R7 one stop pulse per STOP", stop_cnt - s0, 1);

    // R2 mismatched address then more bytes
    w0 = wr_cnt;
    bus_start();
    send_byte(8'hA8, a);
    chk("R2 strap mismatch nack", a, 1'b0);
    send_byte(8'h30, a);
    chk("R2 no ack after mismatch", a, 1'b0);
    send_byte(8'h99, a);
    bus_stop();
    chk("R2 no strobe after mismatch", wr_cnt - w0, 0);

    // R8 STOP in the middle of a data byte
    w0 = wr_cnt; s0 = stop_cnt;
    bus_start();
    send_byte(DEVW, a);
    send_byte(8'h21, a);
    send_bits(8'h00, 5, 1'b0);
    bus_stop();
    chk("R8 no strobe for partial byte (stop)", wr_cnt - w0, 0);
    chk("R7 R8 stop counted", stop_cnt - s0, 1);
    rd_seq(8'h21, 1, r0, r1);
    chk("R8 location unchanged after stop abort", r0, exp_mem[8'h21]);

    // R8 repeated START in the middle of a data byte
    w0 = wr_cnt;
    bus_start();
    send_byte(DEVW, a);
    send_byte(8'h20, a);
    send_bits(8'h99, 3, 1'b0);
    bus_rstart();
    send_byte(DEVR, a);
    chk("R8 address ack after mid-byte start", a, 1'b1);
    recv_byte(r0, 1'b1);
    bus_stop();
    chk("R8 no strobe for partial byte (start)", wr_cnt - w0, 0);
    chk("R8 read after mid-byte start", r0, exp_mem[8'h20]);

    // R9 short SCL glitch inside a data byte
    bus_start();
    send_byte(DEVW, a);
    send_byte(8'h40, a);
    send_byte(8'h6B, a, 1'b1);
    chk("R9 ack despite glitch", a, 1'b1);
    bus_stop();
    exp_mem[8'h40] = 8'h6B;
    rd_seq(8'h40, 1, r0, r1);
    chk("R9 byte intact despite glitch", r0, 8'h6B);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7 run did not complete actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule